// File: doc/BRIEF.md
# Port Traffic Mirroring Engine

This block decides, for every frame event seen on a switch port, which monitor ports must also get a copy of that frame. An event is a single-cycle valid pulse that carries the port number and whether the frame was received or transmitted. The block compares the event against a small set of independent mirror probes and returns, one cycle later, a mask with one bit per switch port. A set bit means that port is a monitor port that must get a copy.

Each probe has a static configuration: an enable, a direction, a membership mask of source ports, and the index of its monitor port. The same source port may belong to several probes, so one event can ask for several copies. Probes that share a monitor port still give a single copy on that port. Copying and queueing the frame data are done by logic downstream of this block.

Top module: `mirror_engine`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `mir_valid` is 0 and `mir_mask` is all zeros.
- R2: `mir_valid` is high exactly in the cycle after a cycle with `evt_valid` high. Whenever `mir_valid` is low, `mir_mask` is all zeros.
- R3: Probe k matches an event when `cfg_enable[k]` is 1, `cfg_dir[k]` equals `evt_dir` (0 = received, 1 = transmitted), and bit `evt_port` of the probe's source mask (`cfg_src_mask[k*NUM_PORTS +: NUM_PORTS]`, where bit i stands for port i) is set. A matching probe sets bit `cfg_monitor[k*PORT_W +: PORT_W]` of `mir_mask`.
- R4: A probe whose enable bit is 0 adds nothing to `mir_mask`, whatever its other fields hold.
- R5: A probe whose direction differs from the event's direction adds nothing to `mir_mask`.
- R6: When several probes match, `mir_mask` is the OR of their monitor one-hot vectors. Probes that share a monitor port give a single set bit.
- R7: A probe whose monitor port equals the event's source port adds no copy. Other matching probes still add theirs, so the bit of the source port in `mir_mask` is never set.
- R8: An event port index of `NUM_PORTS` or more matches no probe. A monitor index of `NUM_PORTS` or more adds no bit.
- R9: `mir_mask` never has more than `NUM_PROBES` bits set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | One-cycle frame event pulse |
| evt_port | input | PORT_W | Port on which the frame was seen |
| evt_dir | input | 1 | 0 = received, 1 = transmitted |
| cfg_enable | input | NUM_PROBES | Per-probe enable |
| cfg_dir | input | NUM_PROBES | Per-probe direction, same encoding as `evt_dir` |
| cfg_src_mask | input | NUM_PROBES*NUM_PORTS | Per-probe source membership, probe k at bits k*NUM_PORTS upward |
| cfg_monitor | input | NUM_PROBES*PORT_W | Per-probe monitor port index, probe k at bits k*PORT_W upward |
| mir_valid | output | 1 | Result valid, one cycle after `evt_valid` |
| mir_mask | output | NUM_PORTS | Monitor ports that must receive a copy |

## Verification
A wrong match term inside one probe would show up as a missing or extra monitor bit in the very next `mir_valid` cycle for an event of the matching port and direction. The scoreboard compares every result word against a model built from the probe rules. Wrong state in the output register would show as a valid pulse at the wrong time, or as a non-zero mask in an idle cycle. These are checked on every cycle after reset. Events are placed so that probes with shared monitors, self-mirroring, mismatched direction and out-of-range indices each decide the result of at least one compared word.

// File: rtl/mirror_pkg.sv
package mirror_pkg;

  typedef enum logic {
    MIR_DIR_RX = 1'b0,
    MIR_DIR_TX = 1'b1
  } mir_dir_e;

  function automatic int unsigned idx_width(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction

endpackage

// File: rtl/mirror_probe_match.sv
module mirror_probe_match
  import mirror_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 30,
  parameter int unsigned PORT_W    = idx_width(NUM_PORTS)
) (
  input  logic                 probe_en,
  input  logic                 probe_dir,
  input  logic [NUM_PORTS-1:0] probe_src,
  input  logic [PORT_W-1:0]    probe_mon,
  input  logic [PORT_W-1:0]    ev_port,
  input  logic                 ev_dir,
  output logic                 hit
);

  localparam int unsigned SPAN = 1 << PORT_W;

  logic [SPAN-1:0] src_span;
  logic            port_ok;
  logic            dir_ok;
  logic            member;
  logic            self_copy;

  always_comb begin
    src_span  = '0;
    src_span[NUM_PORTS-1:0] = probe_src;
    port_ok   = (32'(ev_port) < NUM_PORTS);
    dir_ok    = (mir_dir_e'(probe_dir) == mir_dir_e'(ev_dir));
    member    = port_ok && src_span[ev_port];
    self_copy = (probe_mon == ev_port);
    hit       = probe_en && dir_ok && member && !self_copy;
  end

endmodule

// File: rtl/mirror_mon_decode.sv
module mirror_mon_decode
  import mirror_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 30,
  parameter int unsigned PORT_W    = idx_width(NUM_PORTS)
) (
  input  logic                 hit,
  input  logic [PORT_W-1:0]    mon_idx,
  output logic [NUM_PORTS-1:0] onehot
);

  always_comb begin
    onehot = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (hit && (32'(mon_idx) == p)) onehot[p] = 1'b1;
    end
  end

endmodule

// File: rtl/mirror_out_reg.sv
module mirror_out_reg #(
  parameter int unsigned NUM_PORTS = 30
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [NUM_PORTS-1:0] in_mask,
  output logic                 out_valid,
  output logic [NUM_PORTS-1:0] out_mask
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
    end else begin
      out_valid <= in_valid;
      out_mask  <= in_valid ? in_mask : '0;
    end
  end

  // R2: result valid follows the event pulse by one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_valid_only_after_event: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R2: idle output is clean
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_mask == '0));

endmodule

// File: rtl/mirror_engine.sv
module mirror_engine
  import mirror_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 30,
  parameter int unsigned NUM_PROBES = 3,
  parameter int unsigned PORT_W     = idx_width(NUM_PORTS)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            evt_valid,
  input  logic [PORT_W-1:0]               evt_port,
  input  logic                            evt_dir,
  input  logic [NUM_PROBES-1:0]           cfg_enable,
  input  logic [NUM_PROBES-1:0]           cfg_dir,
  input  logic [NUM_PROBES*NUM_PORTS-1:0] cfg_src_mask,
  input  logic [NUM_PROBES*PORT_W-1:0]    cfg_monitor,
  output logic                            mir_valid,
  output logic [NUM_PORTS-1:0]            mir_mask
);

  logic [NUM_PROBES-1:0] probe_hit;
  logic [NUM_PORTS-1:0]  probe_vec [NUM_PROBES];
  logic [NUM_PORTS-1:0]  merged;

  for (genvar k = 0; k < NUM_PROBES; k++) begin : g_probe
    mirror_probe_match #(
      .NUM_PORTS (NUM_PORTS),
      .PORT_W    (PORT_W)
    ) u_match (
      .probe_en  (cfg_enable[k]),
      .probe_dir (cfg_dir[k]),
      .probe_src (cfg_src_mask[k*NUM_PORTS +: NUM_PORTS]),
      .probe_mon (cfg_monitor[k*PORT_W +: PORT_W]),
      .ev_port   (evt_port),
      .ev_dir    (evt_dir),
      .hit       (probe_hit[k])
    );

    mirror_mon_decode #(
      .NUM_PORTS (NUM_PORTS),
      .PORT_W    (PORT_W)
    ) u_dec (
      .hit     (probe_hit[k]),
      .mon_idx (cfg_monitor[k*PORT_W +: PORT_W]),
      .onehot  (probe_vec[k])
    );
  end

  always_comb begin
    merged = '0;
    for (int k = 0; k < NUM_PROBES; k++) merged = merged | probe_vec[k];
  end

  mirror_out_reg #(
    .NUM_PORTS (NUM_PORTS)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (evt_valid),
    .in_mask   (merged),
    .out_valid (mir_valid),
    .out_mask  (mir_mask)
  );

  // R9: copies bounded by the number of probes
  a_r9_copy_bound: assert property (@(posedge clk) disable iff (rst)
    $countones(mir_mask) <= NUM_PROBES);
  // R4: all probes disabled gives an empty result
  a_r4_all_disabled: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && (cfg_enable == '0)) |=> (mir_mask == '0));
  // R7: the source port is never its own copy target
  a_r7_no_self_copy: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && (32'(evt_port) < NUM_PORTS)) |=> !mir_mask[$past(evt_port)]);
  // R8: out-of-range event port produces nothing
  a_r8_port_range: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && (32'(evt_port) >= NUM_PORTS)) |=> (mir_mask == '0));

endmodule

// File: tb/mirror_engine_tb.sv
module mirror_engine_tb;

  localparam int NP = 30;
  localparam int NK = 3;
  localparam int PW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt_valid = 1'b0;
  logic [PW-1:0] evt_port = '0;
  logic evt_dir = 1'b0;
  logic [NK-1:0] cfg_enable = '0;
  logic [NK-1:0] cfg_dir = '0;
  logic [NP-1:0] src_a [NK];
  logic [PW-1:0] mon_a [NK];
  logic [NK*NP-1:0] cfg_src_mask;
  logic [NK*PW-1:0] cfg_monitor;
  logic mir_valid;
  logic [NP-1:0] mir_mask;

  int checks = 0;
  int fails = 0;
  logic [NP-1:0] exp_q [$];
  string tag_q [$];

  always #2.5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < NK; k++) begin
      cfg_src_mask[k*NP +: NP] = src_a[k];
      cfg_monitor[k*PW +: PW]  = mon_a[k];
    end
  end

  mirror_engine #(.NUM_PORTS(NP), .NUM_PROBES(NK), .PORT_W(PW)) u_dut (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_port(evt_port),
    .evt_dir(evt_dir), .cfg_enable(cfg_enable), .cfg_dir(cfg_dir),
    .cfg_src_mask(cfg_src_mask), .cfg_monitor(cfg_monitor),
    .mir_valid(mir_valid), .mir_mask(mir_mask)
  );

  function automatic logic [NP-1:0] model(input int port, input logic dir);
    logic [NP-1:0] m;
    m = '0;
    for (int k = 0; k < NK; k++) begin
      if (cfg_enable[k] && cfg_dir[k] == dir && port < NP && src_a[k][port]
          && int'(mon_a[k]) < NP && int'(mon_a[k]) != port)
        m[mon_a[k]] = 1'b1;
    end
    return m;
  endfunction

  task automatic fire(input int port, input logic dir, input string tag);
    logic [NP-1:0] e;
    @(negedge clk);
    evt_valid = 1'b1;
    evt_port  = PW'(port);
    evt_dir   = dir;
    e = model(port, dir);
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evt_valid = 1'b0;
    end
  endtask

  task automatic probe_cfg(input int k, input logic en, input logic dir,
                           input logic [NP-1:0] src, input int mon);
    cfg_enable[k] = en;
    cfg_dir[k]    = dir;
    src_a[k]      = src;
    mon_a[k]      = PW'(mon);
  endtask

  task automatic clear_cfg();
    for (int k = 0; k < NK; k++) probe_cfg(k, 1'b0, 1'b0, '0, 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (exp_q.size() > 0) begin
        logic [NP-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (!mir_valid) begin
          fails++;
          $display("FAIL %s: mir_valid=%0b expected 1", t, mir_valid);
        end
        checks++;
        if (mir_mask !== e) begin
          fails++;
          $display("FAIL %s: mir_mask=%h expected %h", t, mir_mask, e);
        end
        checks++;
        if ($countones(mir_mask) > NK) begin
          fails++;
          $display("FAIL R9: copies=%0d expected <=%0d", $countones(mir_mask), NK);
        end
      end else begin
        checks++;
        if (mir_valid !== 1'b0 || mir_mask !== '0) begin
          fails++;
          $display("FAIL R2 idle: valid=%0b mask=%h expected 0/0", mir_valid, mir_mask);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    clear_cfg();
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (mir_valid !== 1'b0 || mir_mask !== '0) begin
      fails++;
      $display("FAIL R1: valid=%0b mask=%h expected 0/0", mir_valid, mir_mask);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (mir_valid !== 1'b0 || mir_mask !== '0) begin
      fails++;
      $display("FAIL R1 after release: valid=%0b mask=%h expected 0/0", mir_valid, mir_mask);
    end

    // R3: receive probe, port 3 -> monitor 10
    probe_cfg(0, 1'b1, 1'b0, NP'(1) << 3, 10);
    fire(3, 1'b0, "R3 rx match");
    // R5: same port, transmit direction
    fire(3, 1'b1, "R5 dir mismatch");
    // R3: port not in mask
    fire(4, 1'b0, "R3 non-member");
    idle(2);
    // R4: disabled probe
    probe_cfg(0, 1'b0, 1'b0, NP'(1) << 3, 10);
    fire(3, 1'b0, "R4 disabled");
    // R3: transmit probe
    probe_cfg(1, 1'b1, 1'b1, (NP'(1) << 7) | (NP'(1) << 3), 20);
    fire(7, 1'b1, "R3 tx match");
    // R6: port 3 in three probes, distinct monitors
    probe_cfg(0, 1'b1, 1'b1, NP'(1) << 3, 10);
    probe_cfg(2, 1'b1, 1'b1, NP'(1) << 3, 29);
    fire(3, 1'b1, "R6 three copies");
    // R6: shared monitor gives one bit
    probe_cfg(2, 1'b1, 1'b1, NP'(1) << 3, 20);
    fire(3, 1'b1, "R6 shared monitor");
    idle(1);
    // R7: source equals monitor on one probe, others still copy
    probe_cfg(0, 1'b1, 1'b1, NP'(1) << 5, 5);
    probe_cfg(1, 1'b1, 1'b1, NP'(1) << 5, 12);
    probe_cfg(2, 1'b0, 1'b1, '0, 0);
    fire(5, 1'b1, "R7 self excluded");
    // R8: event port out of range
    probe_cfg(0, 1'b1, 1'b0, '1, 1);
    probe_cfg(1, 1'b0, 1'b0, '0, 0);
    fire(31, 1'b0, "R8 port range");
    // R8: monitor index out of range
    probe_cfg(0, 1'b1, 1'b0, '1, 30);
    fire(2, 1'b0, "R8 monitor range");
    idle(2);

    // R2/R6: back-to-back pseudo-random traffic
    lf = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      if (n % 20 == 0) begin
        for (int k = 0; k < NK; k++) begin
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          probe_cfg(k, lf[0] | lf[1], lf[2],
                    {lf, lf[13:0]} ^ (NP'(lf) << 7), int'(lf[8:4]) % NP);
        end
      end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      fire(int'(lf[4:0]), lf[5], "R6 random");
      if (lf[9] && lf[10]) idle(1);
    end
    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule